// File: doc/BRIEF.md
# Paged Address Translator with Page Status Tracking

This block sits between a processor's address bus and its RAM arrays. A logical address in the low 4 MB window is split into a 10-bit page index and a 12-bit byte offset. The page index selects one 16-bit entry in an internal 1024-entry page table. The physical page number held in that entry replaces the logical page in the output address. Every translated access also ages the page's two-bit status field: a page moves from fresh to read on its first read, and to dirty on any write. Addresses above the window (I/O, video memory, the page table itself) leave the block unchanged.

Requests arrive on a valid/ready channel. Each accepted request produces a registered response one cycle later, carrying the physical address and the fields of the entry that was looked up, for a separate permission checker. The response has no back-pressure: the consumer must take it in the cycle it is shown. When a lookup needs a status write-back, `req_ready` drops for that one following cycle. This way the next lookup never sees a stale entry. A host port loads and reads back whole entries, and a host write always wins over a pending write-back.

Top module: `page_xlate`

## Requirements
- R1: An accepted address at or above 0x400000 is returned unchanged with `rsp_mapped`=0, and it changes no table entry.
- R2: For an address below 0x400000, bits 21:12 select the entry. The response address is {2'b00, entry[9:0], addr[11:0]}, with `rsp_mapped`=1.
- R3: The response reports the entry as it was looked up. `rsp_wen` is entry bit 15, `rsp_status` is entry bits 14:13, and `rsp_present` is 1 exactly when that status is nonzero.
- R4: For status 1 (fresh), a read sets bits 14:13 to 2 and a write sets them to 3. Bit 15 and bits 12:0 are kept.
- R5: For status 2 or 3, a write sets bits 14:13 to 3. A read leaves the entry unchanged.
- R6: For status 0 (absent), the entry is not changed by a read or a write.
- R7: When an accepted lookup changes a status, `req_ready` is 0 in the cycle its response is shown. The write-back lands at the clock edge that ends that cycle, and `req_ready` is 1 again in the cycle after it.
- R8: A host entry write in the cycle a write-back is pending takes priority. The entry holds exactly the host data, and the write-back is dropped.
- R9: `host_rdata` shows the entry addressed by `host_addr` at the previous clock edge.
- R10: `rsp_exp` is 1 for a translated address at or above 0x200000. It is 0 for lower translated addresses and for all pass-through addresses.
- R11: After reset, `rsp_valid` is 0, `req_ready` is 1 and every entry reads as zero.
- R12: `rsp_valid` is 1 in exactly the cycle after each handshake (`req_valid` and `req_ready` both 1), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 24 | Logical byte address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response fields are valid this cycle |
| rsp_paddr | output | 24 | Physical (or passed-through) address |
| rsp_mapped | output | 1 | Address fell inside the translated window |
| rsp_present | output | 1 | Looked-up page status was nonzero |
| rsp_wen | output | 1 | Looked-up page write-enable bit |
| rsp_status | output | 2 | Looked-up page status before update |
| rsp_exp | output | 1 | Physical address lies in expansion RAM |
| host_we | input | 1 | Host writes `host_wdata` to entry `host_addr` |
| host_addr | input | 10 | Host entry index |
| host_wdata | input | 16 | Host entry write data |
| host_rdata | output | 16 | Entry read back, one cycle latency |

## Verification
The bench targets the status transitions from each of the four states under both access directions. It reads the entry back afterwards. A wrong transition table therefore shows up as a stored value with the status field or the neighbouring bits corrupted.

It probes both ends of the window: offset 0xFFF of page 0, the last byte below 0x400000, and two addresses just above it. An off-by-one window compare would either translate an I/O address or pass a RAM address through.

A host write is aimed at the exact cycle a write-back is pending. If the design let the write-back win, the entry would read back with status 2 instead of the host's value.

Back-to-back accesses to a fresh page check that `req_ready` drops for exactly one cycle. A design without that stall would answer the second access with the stale fresh status.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

  // Entry bit positions are fixed by the entry format.
  localparam int unsigned ENTRY_W = 16;
  localparam int unsigned WEN_POS = 15;
  localparam int unsigned ST_HI   = 14;
  localparam int unsigned ST_LO   = 13;

  typedef enum logic [1:0] {
    PG_ABSENT = 2'd0,
    PG_FRESH  = 2'd1,
    PG_READ   = 2'd2,
    PG_DIRTY  = 2'd3
  } pg_state_e;

  function automatic pg_state_e pg_next(input pg_state_e cur, input logic wr);
    pg_state_e nxt;
    case (cur)
      PG_FRESH: nxt = wr ? PG_DIRTY : PG_READ;
      PG_READ:  nxt = wr ? PG_DIRTY : PG_READ;
      PG_DIRTY: nxt = PG_DIRTY;
      default:  nxt = PG_ABSENT;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pxl_addr_split.sv
module pxl_addr_split #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic [IDX_W-1:0]  idx,
  output logic [OFS_W-1:0]  ofs
);
  localparam int unsigned WIN_LSB = OFS_W + IDX_W;

  assign in_window = (addr[ADDR_W-1:WIN_LSB] == '0);
  assign idx       = addr[WIN_LSB-1:OFS_W];
  assign ofs       = addr[OFS_W-1:0];
endmodule

// File: rtl/pxl_status_upd.sv
module pxl_status_upd
  import pxl_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  logic               wr,
  output logic               present,
  output logic               wen,
  output pg_state_e          cur_st,
  output pg_state_e          new_st,
  output logic               upd
);
  assign cur_st  = pg_state_e'(entry[ST_HI:ST_LO]);
  assign wen     = entry[WEN_POS];
  assign present = (cur_st != PG_ABSENT);
  assign new_st  = pg_next(cur_st, wr);
  assign upd     = present && (new_st != cur_st);
endmodule

// File: rtl/pxl_map_store.sv
module pxl_map_store
  import pxl_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   lk_idx,
  output logic [ENTRY_W-1:0] lk_entry,
  input  logic               host_we,
  input  logic [IDX_W-1:0]   host_addr,
  input  logic [ENTRY_W-1:0] host_wdata,
  output logic [ENTRY_W-1:0] host_rdata,
  input  logic               wb_en,
  input  logic [IDX_W-1:0]   wb_idx,
  input  logic [1:0]         wb_status
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] tbl [DEPTH];

  assign lk_entry = tbl[lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      host_rdata <= '0;
    end else begin
      host_rdata <= tbl[host_addr];
      if (host_we)
        tbl[host_addr] <= host_wdata;
      else if (wb_en)
        tbl[wb_idx][ST_HI:ST_LO] <= wb_status;
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pxl_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned PPN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_mapped,
  output logic              rsp_present,
  output logic              rsp_wen,
  output logic [1:0]        rsp_status,
  output logic              rsp_exp,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata
);
  localparam int unsigned PHYS_W  = PPN_W + OFS_W;
  localparam int unsigned PAD_W   = ADDR_W - PHYS_W;
  localparam int unsigned EXP_BIT = PHYS_W - 1;

  logic               in_win;
  logic [IDX_W-1:0]   lk_idx;
  logic [OFS_W-1:0]   lk_ofs;
  logic [ENTRY_W-1:0] lk_entry;
  logic               lk_present, lk_wen, lk_upd;
  pg_state_e          lk_st, lk_new;
  logic [PHYS_W-1:0]  lk_phys;
  logic               accept;

  // Pending write-back stage
  logic               wb_pend;
  logic [IDX_W-1:0]   wb_idx;
  pg_state_e          wb_st;

  pxl_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) split_i (
    .addr(req_addr), .in_window(in_win), .idx(lk_idx), .ofs(lk_ofs)
  );

  pxl_map_store #(.IDX_W(IDX_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_entry(lk_entry),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .wb_en(wb_pend), .wb_idx(wb_idx), .wb_status(wb_st)
  );

  pxl_status_upd upd_i (
    .entry(lk_entry), .wr(req_write),
    .present(lk_present), .wen(lk_wen),
    .cur_st(lk_st), .new_st(lk_new), .upd(lk_upd)
  );

  assign lk_phys   = {lk_entry[PPN_W-1:0], lk_ofs};
  assign req_ready = !wb_pend;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_pend <= 1'b0;
      wb_idx  <= '0;
      wb_st   <= PG_ABSENT;
    end else begin
      wb_pend <= accept && in_win && lk_upd;
      wb_idx  <= lk_idx;
      wb_st   <= lk_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_mapped  <= 1'b0;
      rsp_present <= 1'b0;
      rsp_wen     <= 1'b0;
      rsp_status  <= 2'd0;
      rsp_exp     <= 1'b0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        if (in_win) begin
          rsp_paddr   <= {{PAD_W{1'b0}}, lk_phys};
          rsp_mapped  <= 1'b1;
          rsp_present <= lk_present;
          rsp_wen     <= lk_wen;
          rsp_status  <= lk_st;
          rsp_exp     <= lk_phys[EXP_BIT];
        end else begin
          rsp_paddr   <= req_addr;
          rsp_mapped  <= 1'b0;
          rsp_present <= 1'b0;
          rsp_wen     <= 1'b0;
          rsp_status  <= 2'd0;
          rsp_exp     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pxl_checker.sv
module pxl_checker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned IDX_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_mapped,
  input logic              rsp_present,
  input logic [1:0]        rsp_status,
  input logic              rsp_exp
);
  localparam int unsigned WIN_LSB = OFS_W + IDX_W;

  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R12

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid); // R12

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[ADDR_W-1:WIN_LSB] != '0)
      |=> (!rsp_mapped && rsp_paddr == $past(req_addr))); // R1

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[ADDR_W-1:WIN_LSB] == '0)
      |=> (rsp_mapped && rsp_paddr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0]))); // R2

  AST_FRESH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mapped && rsp_status == 2'd1) |-> !req_ready); // R7

  AST_READY_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready); // R7

  AST_ABSENT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0) |-> req_ready); // R6

  AST_PASS_NO_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_mapped) |-> (!rsp_exp && !rsp_present)); // R10
endmodule

bind page_xlate pxl_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_mapped(rsp_mapped), .rsp_present(rsp_present),
  .rsp_status(rsp_status), .rsp_exp(rsp_exp)
);

// File: tb/page_xlate_tb_top.sv
module page_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [23:0] rsp_paddr;
  logic        rsp_mapped, rsp_present, rsp_wen, rsp_exp;
  logic [1:0]  rsp_status;
  logic        host_we = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  page_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_mapped(rsp_mapped), .rsp_present(rsp_present),
    .rsp_wen(rsp_wen), .rsp_status(rsp_status), .rsp_exp(rsp_exp),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  typedef struct packed {
    logic [23:0] paddr;
    logic        mapped;
    logic        present;
    logic        wen;
    logic [1:0]  status;
    logic        exp;
    logic        stall;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] model [1024];

  function automatic logic [1:0] model_next(input logic [1:0] st, input logic wr);
    if (st == 2'd0) return 2'd0;
    if (wr) return 2'd3;
    if (st == 2'd1) return 2'd2;
    return st;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: compares each response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R12 unexpected response", 32'(rsp_paddr), 32'hFFFFFFFF);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rsp_paddr == e.paddr, e.mapped ? "R2 paddr" : "R1 paddr", 32'(rsp_paddr), 32'(e.paddr));
        check(rsp_mapped == e.mapped, "R1 mapped", 32'(rsp_mapped), 32'(e.mapped));
        check({rsp_present, rsp_wen, rsp_status} == {e.present, e.wen, e.status},
              "R3 flags", 32'({rsp_present, rsp_wen, rsp_status}), 32'({e.present, e.wen, e.status}));
        check(rsp_exp == e.exp, "R10 exp", 32'(rsp_exp), 32'(e.exp));
        check(req_ready == !e.stall, "R7 ready", 32'(req_ready), 32'(!e.stall));
      end
    end
  end

  function automatic exp_t predict(input logic [23:0] a, input logic wr);
    exp_t e;
    e = '0;
    if (a >= 24'h400000) begin
      e.paddr = a;
    end else begin
      logic [15:0] ent;
      logic [1:0]  nx;
      ent = model[a[21:12]];
      e.paddr   = {2'b00, ent[9:0], a[11:0]};
      e.mapped  = 1'b1;
      e.status  = ent[14:13];
      e.present = (ent[14:13] != 2'd0);
      e.wen     = ent[15];
      e.exp     = ent[9];
      nx = model_next(ent[14:13], wr);
      e.stall = (nx != ent[14:13]);
      model[a[21:12]][14:13] = nx;
    end
    return e;
  endfunction

  task automatic do_access(input logic [23:0] a, input logic wr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_write = wr;
    sb_q.push_back(predict(a, wr));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic host_write(input logic [9:0] i, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = i; host_wdata = d;
    model[i] = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_check(input logic [9:0] i, input string req);
    @(negedge clk);
    host_addr = i;
    @(negedge clk);
    check(host_rdata == model[i], req, 32'(host_rdata), 32'(model[i]));
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(1'b0, "watchdog", 32'(cyc), 32'd100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(rsp_valid == 1'b0, "R11 rsp_valid", 32'(rsp_valid), 0);
    check(req_ready == 1'b1, "R11 req_ready", 32'(req_ready), 1);
    rst_n = 1'b1;
    host_check(10'd0, "R11 entry zero");
    host_check(10'd777, "R11 entry zero");

    host_write(10'd5,  16'hA123); // wen=1 status=1 ppn=0x123
    host_write(10'd6,  16'h22A5); // wen=0 status=1 ppn=0x2A5 (expansion)
    host_write(10'd7,  16'h9C55); // status=0
    host_write(10'd8,  16'h4010); // status=2
    host_write(10'd9,  16'hFF0F); // status=3, bits 12:8 set
    host_write(10'd1023, 16'h23FF);
    host_check(10'd9, "R9 readback");

    // R4: fresh page read -> 2, then write -> 3
    do_access(24'h005ABC, 1'b0);
    drain(); host_check(10'd5, "R4 fresh read");
    do_access(24'h005002, 1'b1);
    drain(); host_check(10'd5, "R5 read page written");
    do_access(24'h005FFE, 1'b0);
    // R4: fresh write goes straight to dirty, expansion page (R10)
    do_access(24'h006010, 1'b1);
    drain(); host_check(10'd6, "R4 fresh write");
    // R6: absent page, read and write
    do_access(24'h007100, 1'b0);
    do_access(24'h007200, 1'b1);
    drain(); host_check(10'd7, "R6 absent untouched");
    // R5: read on read page unchanged, then write -> dirty
    do_access(24'h008333, 1'b0);
    drain(); host_check(10'd8, "R5 read keeps");
    do_access(24'h008334, 1'b1);
    drain(); host_check(10'd8, "R5 write dirty");
    do_access(24'h009444, 1'b1);
    drain(); host_check(10'd9, "R5 dirty keeps low bits");
    // R1: pass-through at and above the window edge
    do_access(24'h400000, 1'b1);
    do_access(24'hC00010, 1'b0);
    do_access(24'h4A1234, 1'b0);
    // R2: window edges
    do_access(24'h000FFF, 1'b0);
    do_access(24'h3FFFFF, 1'b0);
    drain(); host_check(10'd1023, "R4 last page read");

    // R8: host write collides with pending write-back
    host_write(10'd10, 16'h2001);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'h00A000; req_write = 1'b0;
    sb_q.push_back(predict(24'h00A000, 1'b0));
    @(negedge clk);
    req_valid = 1'b0;
    host_we = 1'b1; host_addr = 10'd10; host_wdata = 16'h2055;
    model[10] = 16'h2055;
    @(negedge clk);
    host_we = 1'b0;
    drain(); host_check(10'd10, "R8 host wins");
    do_access(24'h00A008, 1'b0); // still fresh: stalls again (R7)
    drain(); host_check(10'd10, "R4 after collision");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule